// File: doc/BRIEF.md
# Quiet Floating-Point Compare and Min/Max Unit

This unit evaluates ordered comparisons (equal, greater-than, greater-or-equal) and selects the minimum or maximum of two IEEE-754 operands, in either single or double precision. A caller presents two operands, a precision select and an operation code together with a valid strobe. One clock later the unit returns a single-bit predicate for compares or a 64-bit value for min/max, along with a valid pulse.

Comparisons are fully quiet: a NaN operand of either kind makes every compare false and never raises an exception. Min/max ignores a NaN operand in favour of the numeric one. When both operands are NaN, it yields a canonical NaN whose bits are all ones. Only a signalling NaN reaching min/max raises the invalid exception.

Exceptions are kept in a five-bit sticky field that occupies bits 5..1 of a status word. Bits stay set until a clear request with a bit mask removes them.

Top module: `fp_quiet_cmp_minmax`

## Requirements
- R1: `flags_o` is indexed [5:1] and maps to status bits 1 invalid, 2 divide-by-zero, 3 overflow, 4 underflow and 5 inexact. This unit can only ever set bit 1, so bits 5..2 always read zero.
- R2: `valid_o` is high in the cycle after each cycle in which `valid_i` was sampled high, and is low otherwise. `pred_o` and `result_o` for that request are presented in the same cycle. Operation codes on `op_i`: 0 equal, 1 greater-than, 2 greater-or-equal, 3 minimum, 4 maximum.
- R3: Codes 0, 1 and 2 return `pred_o`=0 whenever either operand is any NaN (quiet or signalling), and never change `flags_o`.
- R4: For non-NaN operands the compares follow numeric order, including infinities, subnormals and negative values, and +0 equals -0.
- R5: For min/max with exactly one NaN operand, `result_o` is the other operand, bit for bit.
- R6: For min/max with both operands NaN, `result_o` is all ones: 0x00000000FFFFFFFF in single precision and 0xFFFFFFFFFFFFFFFF in double.
- R7: In min/max, a signalling NaN (exponent all ones, mantissa nonzero, mantissa top bit 0) in either operand sets invalid (`flags_o[1]`) in the cycle the result appears. A quiet NaN sets nothing.
- R8: Flags are sticky. When `clr_en_i` is high, the bits set in `clr_mask_i` are cleared at the next edge. A new exception raised in the same cycle takes precedence over the clear, and reset clears all flags.
- R9: Min/max of two zeros of opposite sign returns -0 for min and +0 for max. Otherwise min returns the numerically smaller operand and max the larger.
- R10: With `prec_dbl_i`=0 only bits 31..0 of each operand are used, bits 63..32 have no effect, and bits 63..32 of `result_o` are zero.
- R11: Compare codes drive `result_o` to zero, min/max drive `pred_o` to zero, and codes 5..7 give `pred_o`=0, `result_o`=0 and no flag change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Request strobe |
| op_i | input | 3 | Operation code |
| prec_dbl_i | input | 1 | 1 = double precision, 0 = single |
| a_i | input | 64 | First operand |
| b_i | input | 64 | Second operand |
| clr_en_i | input | 1 | Flag clear request |
| clr_mask_i | input | 5 | Flag bits to clear, indexed [5:1] |
| valid_o | output | 1 | Result valid |
| pred_o | output | 1 | Compare predicate |
| result_o | output | 64 | Min/max value |
| flags_o | output | 5 | Sticky exception flags, indexed [5:1] |

## Verification
Every result of a request, whether the predicate, the value or a raised invalid flag, is due exactly one rising edge after the strobe is sampled. A flag clear also takes effect at the first edge. The bench's reference model advances on each rising edge using the inputs held across it. The design's outputs are then compared against the model at the following falling edge, so each comparison falls in the single cycle where the answer belongs. Directed sequences cover NaN, zero, infinity and mask-clear cases, and a seeded random mix follows them.

// File: rtl/fpcm_pkg.sv
package fpcm_pkg;

   typedef enum logic [2:0] {
      FPCM_EQ  = 3'd0,
      FPCM_GT  = 3'd1,
      FPCM_GE  = 3'd2,
      FPCM_MIN = 3'd3,
      FPCM_MAX = 3'd4
   } fpcm_op_e;

   // status-word positions of the exception flags
   localparam int FLG_INVALID   = 1;
   localparam int FLG_DIVZERO   = 2;
   localparam int FLG_OVERFLOW  = 3;
   localparam int FLG_UNDERFLOW = 4;
   localparam int FLG_INEXACT   = 5;
   localparam int FLG_LO        = FLG_INVALID;
   localparam int FLG_HI        = FLG_INEXACT;
   localparam int FLG_N         = FLG_HI - FLG_LO + 1;

   typedef struct packed {
      logic nan;
      logic snan;
      logic zero;
      logic sign;
   } fpcm_class_t;

endpackage

// File: rtl/fpcm_classify.sv
module fpcm_classify
   import fpcm_pkg::*;
#(
   parameter int EW = 8,
   parameter int MW = 23
) (
   input  logic [EW+MW:0]   val_i,
   output fpcm_class_t      cls_o,
   output logic [EW+MW-1:0] mag_o
);

   logic [EW-1:0] expo;
   logic [MW-1:0] mant;

   assign expo = val_i[EW+MW-1:MW];
   assign mant = val_i[MW-1:0];

   always_comb begin
      cls_o.sign = val_i[EW+MW];
      cls_o.nan  = (&expo) & (|mant);
      cls_o.snan = (&expo) & (|mant) & ~mant[MW-1];
      cls_o.zero = ~|val_i[EW+MW-1:0];
   end

   assign mag_o = val_i[EW+MW-1:0];

endmodule

// File: rtl/fpcm_order.sv
module fpcm_order #(
   parameter int W = 63
) (
   input  logic         a_sign_i,
   input  logic         a_zero_i,
   input  logic [W-1:0] a_mag_i,
   input  logic         b_sign_i,
   input  logic         b_zero_i,
   input  logic [W-1:0] b_mag_i,
   output logic         eq_o,
   output logic         gt_o
);

   always_comb begin
      if (a_zero_i && b_zero_i) begin
         eq_o = 1'b1;
         gt_o = 1'b0;
      end else if (a_sign_i != b_sign_i) begin
         eq_o = 1'b0;
         gt_o = ~a_sign_i;
      end else begin
         eq_o = (a_mag_i == b_mag_i);
         gt_o = a_sign_i ? (a_mag_i < b_mag_i) : (a_mag_i > b_mag_i);
      end
   end

endmodule

// File: rtl/fpcm_flags.sv
module fpcm_flags #(
   parameter int LO = 1,
   parameter int HI = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr_en_i,
   input  logic [HI:LO]  clr_mask_i,
   input  logic [HI:LO]  set_i,
   output logic [HI:LO]  flags_o
);

   for (genvar i = LO; i <= HI; i++) begin : g_bit
      logic bit_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            bit_q <= 1'b0;
         end else begin
            bit_q <= (bit_q & ~(clr_en_i & clr_mask_i[i])) | set_i[i];
         end
      end
      assign flags_o[i] = bit_q;
   end

endmodule

// File: rtl/fp_quiet_cmp_minmax.sv
module fp_quiet_cmp_minmax
   import fpcm_pkg::*;
#(
   parameter int SP_EXP = 8,
   parameter int SP_MAN = 23,
   parameter int DP_EXP = 11,
   parameter int DP_MAN = 52
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      valid_i,
   input  logic [2:0]                op_i,
   input  logic                      prec_dbl_i,
   input  logic [DP_EXP+DP_MAN:0]    a_i,
   input  logic [DP_EXP+DP_MAN:0]    b_i,
   input  logic                      clr_en_i,
   input  logic [FLG_HI:FLG_LO]      clr_mask_i,
   output logic                      valid_o,
   output logic                      pred_o,
   output logic [DP_EXP+DP_MAN:0]    result_o,
   output logic [FLG_HI:FLG_LO]      flags_o
);

   localparam int SP_W  = SP_EXP + SP_MAN + 1;
   localparam int DP_W  = DP_EXP + DP_MAN + 1;
   localparam int MAG_W = DP_W - 1;
   localparam int PAD_W = DP_W - SP_W;

   initial begin
      assert (SP_EXP >= 2 && SP_MAN >= 2)
         else $error("fp_quiet_cmp_minmax: single format too narrow");
      assert (DP_EXP > SP_EXP && DP_MAN > SP_MAN)
         else $error("fp_quiet_cmp_minmax: double format must exceed single");
   end

   // ---------------- operand classification, both formats ----------------
   fpcm_class_t            s_cls [2];
   fpcm_class_t            d_cls [2];
   logic [SP_W-2:0]        s_mag [2];
   logic [DP_W-2:0]        d_mag [2];
   logic [DP_W-1:0]        ext_val [2];

   for (genvar g = 0; g < 2; g++) begin : g_opnd
      logic [DP_W-1:0] opnd;
      assign opnd = (g == 0) ? a_i : b_i;

      fpcm_classify #(.EW(SP_EXP), .MW(SP_MAN)) u_cls_sp (
         .val_i (opnd[SP_W-1:0]),
         .cls_o (s_cls[g]),
         .mag_o (s_mag[g])
      );

      fpcm_classify #(.EW(DP_EXP), .MW(DP_MAN)) u_cls_dp (
         .val_i (opnd),
         .cls_o (d_cls[g]),
         .mag_o (d_mag[g])
      );

      assign ext_val[g] = prec_dbl_i ? opnd : {{PAD_W{1'b0}}, opnd[SP_W-1:0]};
   end

   fpcm_class_t       cls_a, cls_b;
   logic [MAG_W-1:0]  mag_a, mag_b;

   assign cls_a = prec_dbl_i ? d_cls[0] : s_cls[0];
   assign cls_b = prec_dbl_i ? d_cls[1] : s_cls[1];
   assign mag_a = prec_dbl_i ? d_mag[0] : MAG_W'(s_mag[0]);
   assign mag_b = prec_dbl_i ? d_mag[1] : MAG_W'(s_mag[1]);

   // ---------------- numeric ordering ----------------
   logic a_eq_b, a_gt_b;

   fpcm_order #(.W(MAG_W)) u_order (
      .a_sign_i (cls_a.sign),
      .a_zero_i (cls_a.zero),
      .a_mag_i  (mag_a),
      .b_sign_i (cls_b.sign),
      .b_zero_i (cls_b.zero),
      .b_mag_i  (mag_b),
      .eq_o     (a_eq_b),
      .gt_o     (a_gt_b)
   );

   // ---------------- operation decode ----------------
   fpcm_op_e          op;
   logic              any_nan, both_nan, both_zero, is_minmax;
   logic              min_pick_a, max_pick_a;
   logic [DP_W-1:0]   canon_nan, ordered_val;
   logic              pred_d;
   logic [DP_W-1:0]   res_d;
   logic [FLG_HI:FLG_LO] set_d;

   assign op         = fpcm_op_e'(op_i);
   assign any_nan    = cls_a.nan | cls_b.nan;
   assign both_nan   = cls_a.nan & cls_b.nan;
   assign both_zero  = cls_a.zero & cls_b.zero;
   assign is_minmax  = (op == FPCM_MIN) || (op == FPCM_MAX);
   assign canon_nan  = prec_dbl_i ? {DP_W{1'b1}} : {{PAD_W{1'b0}}, {SP_W{1'b1}}};

   // opposite-signed zeros: min takes the negative one, max the positive one
   assign min_pick_a = both_zero ? cls_a.sign  : ~a_gt_b;
   assign max_pick_a = both_zero ? ~cls_a.sign : (a_gt_b | a_eq_b);

   always_comb begin
      if (op == FPCM_MIN) ordered_val = min_pick_a ? ext_val[0] : ext_val[1];
      else                ordered_val = max_pick_a ? ext_val[0] : ext_val[1];
   end

   always_comb begin
      pred_d = 1'b0;
      res_d  = '0;
      unique case (op)
         FPCM_EQ:  pred_d = ~any_nan & a_eq_b;
         FPCM_GT:  pred_d = ~any_nan & a_gt_b;
         FPCM_GE:  pred_d = ~any_nan & (a_gt_b | a_eq_b);
         FPCM_MIN,
         FPCM_MAX: begin
            if (both_nan)       res_d = canon_nan;
            else if (cls_a.nan) res_d = ext_val[1];
            else if (cls_b.nan) res_d = ext_val[0];
            else                res_d = ordered_val;
         end
         default: ;
      endcase
   end

   always_comb begin
      set_d = '0;
      set_d[FLG_INVALID] = valid_i & is_minmax & (cls_a.snan | cls_b.snan);
   end

   // ---------------- output stage ----------------
   logic            valid_q, pred_q;
   logic [DP_W-1:0] res_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         pred_q  <= 1'b0;
         res_q   <= '0;
      end else begin
         valid_q <= valid_i;
         if (valid_i) begin
            pred_q <= pred_d;
            res_q  <= res_d;
         end
      end
   end

   fpcm_flags #(.LO(FLG_LO), .HI(FLG_HI)) u_flags (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr_en_i   (clr_en_i),
      .clr_mask_i (clr_mask_i),
      .set_i      (set_d),
      .flags_o    (flags_o)
   );

   assign valid_o  = valid_q;
   assign pred_o   = pred_q;
   assign result_o = res_q;

endmodule

// File: rtl/fpcm_checker.sv
module fpcm_checker
   import fpcm_pkg::*;
#(
   parameter int SP_EXP = 8,
   parameter int SP_MAN = 23,
   parameter int DP_EXP = 11,
   parameter int DP_MAN = 52
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    valid_i,
   input logic [2:0]              op_i,
   input logic                    prec_dbl_i,
   input logic [DP_EXP+DP_MAN:0]  a_i,
   input logic [DP_EXP+DP_MAN:0]  b_i,
   input logic                    clr_en_i,
   input logic [FLG_HI:FLG_LO]    clr_mask_i,
   input logic                    valid_o,
   input logic                    pred_o,
   input logic [DP_EXP+DP_MAN:0]  result_o,
   input logic [FLG_HI:FLG_LO]    flags_o
);

   localparam int SP_W = SP_EXP + SP_MAN + 1;
   localparam int DP_W = DP_EXP + DP_MAN + 1;

   function automatic logic nan_of(input logic [DP_W-1:0] x, input logic dbl);
      if (dbl) return (&x[DP_W-2:DP_MAN]) & (|x[DP_MAN-1:0]);
      return (&x[SP_W-2:SP_MAN]) & (|x[SP_MAN-1:0]);
   endfunction

   function automatic logic snan_of(input logic [DP_W-1:0] x, input logic dbl);
      if (dbl) return nan_of(x, dbl) & ~x[DP_MAN-1];
      return nan_of(x, dbl) & ~x[SP_MAN-1];
   endfunction

   logic is_cmp, is_mm, a_nan, b_nan, any_snan;
   assign is_cmp   = (op_i <= 3'd2);
   assign is_mm    = (op_i == 3'd3) || (op_i == 3'd4);
   assign a_nan    = nan_of(a_i, prec_dbl_i);
   assign b_nan    = nan_of(b_i, prec_dbl_i);
   assign any_snan = snan_of(a_i, prec_dbl_i) | snan_of(b_i, prec_dbl_i);

   assert_unused_flags_R1: assert property (@(posedge clk) disable iff (!rst_n)
      flags_o[FLG_HI:FLG_DIVZERO] == '0);

   assert_valid_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (valid_o == $past(valid_i)));

   assert_cmp_nan_false_R3: assert property (@(posedge clk) disable iff (!rst_n)
      valid_i && is_cmp && (a_nan || b_nan) |=> !pred_o);

   assert_cmp_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      valid_i && is_cmp && !clr_en_i |=> $stable(flags_o));

   assert_canon_nan_R6: assert property (@(posedge clk) disable iff (!rst_n)
      valid_i && is_mm && a_nan && b_nan |=>
         result_o == ($past(prec_dbl_i) ? {DP_W{1'b1}}
                                        : {{(DP_W-SP_W){1'b0}}, {SP_W{1'b1}}}));

   assert_snan_invalid_R7: assert property (@(posedge clk) disable iff (!rst_n)
      valid_i && is_mm && any_snan |=> flags_o[FLG_INVALID]);

   assert_sticky_invalid_R8: assert property (@(posedge clk) disable iff (!rst_n)
      flags_o[FLG_INVALID] && !(clr_en_i && clr_mask_i[FLG_INVALID]) |=> flags_o[FLG_INVALID]);

endmodule

bind fp_quiet_cmp_minmax fpcm_checker #(
   .SP_EXP (SP_EXP),
   .SP_MAN (SP_MAN),
   .DP_EXP (DP_EXP),
   .DP_MAN (DP_MAN)
) u_fpcm_checker (.*);

// File: tb/test_fp_quiet_cmp_minmax.sv
module test_fp_quiet_cmp_minmax;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        valid_i = 1'b0;
   logic [2:0]  op_i = '0;
   logic        prec_dbl_i = 1'b0;
   logic [63:0] a_i = '0;
   logic [63:0] b_i = '0;
   logic        clr_en_i = 1'b0;
   logic [5:1]  clr_mask_i = '0;
   logic        valid_o, pred_o;
   logic [63:0] result_o;
   logic [5:1]  flags_o;

   int checks = 0;
   int errors = 0;
   bit started = 1'b0;
   string cur_tag = "R2 R8 reset";

   always #5 clk = ~clk;

   fp_quiet_cmp_minmax i_fp_quiet_cmp_minmax (
      .clk, .rst_n, .valid_i, .op_i, .prec_dbl_i, .a_i, .b_i,
      .clr_en_i, .clr_mask_i, .valid_o, .pred_o, .result_o, .flags_o
   );

   // ---------------- behavioural reference ----------------
   function automatic bit m_nan(input logic [63:0] x, input bit dbl);
      if (dbl) return x[62:52] == 11'h7FF && x[51:0] != 0;
      return x[30:23] == 8'hFF && x[22:0] != 0;
   endfunction

   function automatic bit m_snan(input logic [63:0] x, input bit dbl);
      return m_nan(x, dbl) && (dbl ? !x[51] : !x[22]);
   endfunction

   function automatic real m_real(input logic [63:0] x, input bit dbl);
      int  e;
      real m, r;
      if (dbl) return $bitstoreal(x);
      e = int'(x[30:23]);
      m = real'(x[22:0]);
      if (e == 255)    r = $bitstoreal(64'h7FF0_0000_0000_0000);
      else if (e == 0) r = m * (2.0 ** (-149.0));
      else             r = (m + 8388608.0) * (2.0 ** real'(e - 150));
      return x[31] ? -r : r;
   endfunction

   logic        exp_valid = 1'b0;
   logic        exp_pred = 1'b0;
   logic [63:0] exp_res = '0;
   logic [5:1]  exp_flags = '0;
   string       exp_tag = "R2 R8 reset";

   always @(posedge clk) begin
      started = 1'b1;
      if (!rst_n) begin
         exp_valid = 1'b0;
         exp_pred  = 1'b0;
         exp_res   = '0;
         exp_flags = '0;
         exp_tag   = cur_tag;
      end else begin
         logic [63:0] av, bv;
         bit an, bn, mm, inv, zz;
         real ra, rb;
         av = prec_dbl_i ? a_i : {32'h0, a_i[31:0]};
         bv = prec_dbl_i ? b_i : {32'h0, b_i[31:0]};
         an = m_nan(av, prec_dbl_i);
         bn = m_nan(bv, prec_dbl_i);
         ra = m_real(av, prec_dbl_i);
         rb = m_real(bv, prec_dbl_i);
         zz = (ra == 0.0) && (rb == 0.0);
         mm = (op_i == 3'd3) || (op_i == 3'd4);
         inv = valid_i && mm && (m_snan(av, prec_dbl_i) || m_snan(bv, prec_dbl_i));
         if (clr_en_i) exp_flags = exp_flags & ~clr_mask_i;
         if (inv) exp_flags[1] = 1'b1;
         exp_valid = valid_i;
         exp_tag = cur_tag;
         if (valid_i) begin
            exp_pred = 1'b0;
            exp_res  = '0;
            case (op_i)
               3'd0: exp_pred = !an && !bn && (ra == rb);
               3'd1: exp_pred = !an && !bn && (ra > rb);
               3'd2: exp_pred = !an && !bn && (ra >= rb);
               3'd3, 3'd4: begin
                  if (an && bn)
                     exp_res = prec_dbl_i ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
                  else if (an) exp_res = bv;
                  else if (bn) exp_res = av;
                  else if (zz) begin
                     bit neg_a;
                     neg_a = prec_dbl_i ? av[63] : av[31];
                     if (op_i == 3'd3) exp_res = neg_a ? av : bv;
                     else              exp_res = neg_a ? bv : av;
                  end else if (op_i == 3'd3) exp_res = (rb < ra) ? bv : av;
                  else                       exp_res = (rb > ra) ? bv : av;
               end
               default: ;
            endcase
         end
      end
   end

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=0x%0h expected=0x%0h at %0t", tag, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (started) begin
         chk(valid_o === exp_valid, {exp_tag, " R2"}, "valid_o", 64'(valid_o), 64'(exp_valid));
         chk(flags_o === exp_flags, {exp_tag, " R1 R8"}, "flags_o", 64'(flags_o), 64'(exp_flags));
         if (exp_valid) begin
            chk(pred_o === exp_pred, exp_tag, "pred_o", 64'(pred_o), 64'(exp_pred));
            chk(result_o === exp_res, exp_tag, "result_o", result_o, exp_res);
         end
      end
   end

   // ---------------- stimulus ----------------
   task automatic step(input bit v, input logic [2:0] op, input bit dbl,
                       input logic [63:0] a, input logic [63:0] b,
                       input bit ce, input logic [5:1] m, input string tag);
      @(negedge clk);
      valid_i = v; op_i = op; prec_dbl_i = dbl; a_i = a; b_i = b;
      clr_en_i = ce; clr_mask_i = m; cur_tag = tag;
   endtask

   task automatic req(input logic [2:0] op, input bit dbl,
                      input logic [63:0] a, input logic [63:0] b, input string tag);
      step(1'b1, op, dbl, a, b, 1'b0, 5'h0, tag);
   endtask

   task automatic idle(input string tag);
      step(1'b0, 3'd0, 1'b0, 64'h0, 64'h0, 1'b0, 5'h0, tag);
   endtask

   task automatic clr(input logic [5:1] m, input string tag);
      step(1'b0, 3'd0, 1'b0, 64'h0, 64'h0, 1'b1, m, tag);
   endtask

   localparam logic [63:0] D_ONE  = 64'h3FF0_0000_0000_0000;
   localparam logic [63:0] D_TWO  = 64'h4000_0000_0000_0000;
   localparam logic [63:0] D_MONE = 64'hBFF0_0000_0000_0000;
   localparam logic [63:0] D_QNAN = 64'h7FF8_0000_0000_0000;
   localparam logic [63:0] D_SNAN = 64'h7FF7_0000_0000_0000;
   localparam logic [63:0] D_PINF = 64'h7FF0_0000_0000_0000;
   localparam logic [63:0] D_NZ   = 64'h8000_0000_0000_0000;

   function automatic logic [63:0] pool(input int idx, input bit dbl);
      logic [63:0] d [12];
      logic [31:0] s [12];
      d = '{D_ONE, D_MONE, D_TWO, 64'h0, D_NZ, D_QNAN, D_SNAN, D_PINF,
            64'hFFF0_0000_0000_0000, 64'hBD73_1F75_0000_0000, 64'h1, 64'hC000_0000_0000_0000};
      s = '{32'h3F80_0000, 32'hBF80_0000, 32'h4000_0000, 32'h0, 32'h8000_0000, 32'h7FC0_0000,
            32'h7F80_0001, 32'h7F80_0000, 32'hFF80_0000, 32'hAB98_FBA8, 32'h1, 32'h3460_01D6};
      if (dbl) return d[idx];
      return {$urandom(), s[idx]};
   endfunction

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      idle("R2 R8 reset");
      idle("R2 R8 reset");

      // R3: quiet compares against NaNs
      req(3'd0, 1'b1, D_QNAN, D_ONE, "R3 eq qnan dbl");
      req(3'd1, 1'b1, D_QNAN, D_ONE, "R3 gt qnan dbl");
      req(3'd2, 1'b1, D_ONE, D_SNAN, "R3 ge snan dbl");
      req(3'd0, 1'b0, 64'h7FC0_0000, 64'h3F80_0000, "R3 eq qnan sgl");
      req(3'd2, 1'b0, 64'h7F80_0001, 64'h7F80_0001, "R3 ge snan sgl");
      // R4: ordered compares
      req(3'd0, 1'b1, 64'h0, D_NZ, "R4 +0 eq -0");
      req(3'd2, 1'b0, 64'h8000_0000, 64'h0, "R4 -0 ge +0");
      req(3'd1, 1'b1, D_MONE, 64'hC000_0000_0000_0000, "R4 -1 gt -2");
      req(3'd1, 1'b1, D_ONE, D_TWO, "R4 1 gt 2");
      req(3'd1, 1'b0, 64'h7F80_0000, 64'h7F7F_FFFF, "R4 inf gt max");
      req(3'd1, 1'b0, 64'h1, 64'h0, "R4 denorm gt 0");
      // R5 / R6 / R7
      req(3'd3, 1'b0, 64'h7FC0_0000, 64'h3F80_0000, "R5 min qnan sgl");
      req(3'd4, 1'b1, D_QNAN, D_ONE, "R5 R7 max qnan dbl no flag");
      req(3'd3, 1'b0, 64'h7FC0_0000, 64'h7FC0_0000, "R6 min both nan sgl");
      req(3'd4, 1'b1, D_QNAN, D_QNAN, "R6 max both nan dbl");
      idle("R7 still clear");
      req(3'd3, 1'b1, D_SNAN, D_ONE, "R5 R7 min snan dbl");
      idle("R1 R7 invalid set");
      // R8: sticky and mask clearing
      clr(5'b11110, "R8 clear other bits");
      idle("R8 invalid held");
      clr(5'b00001, "R8 clear invalid");
      idle("R8 invalid cleared");
      req(3'd4, 1'b1, D_SNAN, D_SNAN, "R6 R7 max both snan");
      step(1'b1, 3'd3, 1'b1, D_ONE, D_SNAN, 1'b1, 5'b11111, "R8 set beats clear");
      idle("R8 after set+clear");
      clr(5'b11111, "R8 clear all");
      // R9: zeros and plain ordering
      req(3'd3, 1'b1, 64'h0, D_NZ, "R9 min +0 -0");
      req(3'd4, 1'b1, 64'h0, D_NZ, "R9 max +0 -0");
      req(3'd3, 1'b0, 64'h8000_0000, 64'h0, "R9 min -0 +0 sgl");
      req(3'd4, 1'b0, 64'h8000_0000, 64'h0, "R9 max -0 +0 sgl");
      req(3'd3, 1'b1, D_TWO, D_MONE, "R9 min 2 -1");
      req(3'd4, 1'b0, 64'hAB98_FBA8, 64'h3460_01D6, "R9 max sgl");
      // R10: upper bits ignored in single
      req(3'd4, 1'b0, 64'hDEAD_BEEF_3F80_0000, 64'h1234_5678_4000_0000, "R10 upper ignored max");
      req(3'd0, 1'b0, 64'hFFFF_0000_3F80_0000, 64'h0000_FFFF_3F80_0000, "R10 upper ignored eq");
      // R11: reserved codes
      req(3'd5, 1'b1, D_SNAN, D_ONE, "R11 code 5");
      req(3'd7, 1'b0, 64'h7F80_0001, 64'h0, "R11 code 7");
      idle("R11 no flag");

      // seeded random mix
      for (int n = 0; n < 400; n++) begin
         bit          dbl;
         logic [2:0]  op;
         bit          ce;
         string       tg;
         dbl = $urandom_range(0, 1);
         op  = 3'($urandom_range(0, 7));
         ce  = ($urandom_range(0, 7) == 0);
         if (op <= 3'd2)      tg = "R3 R4 rnd cmp";
         else if (op <= 3'd4) tg = "R5 R6 R7 R9 rnd minmax";
         else                 tg = "R11 rnd reserved";
         if (ce) tg = {tg, " R8"};
         step($urandom_range(0, 3) != 0, op, dbl,
              pool($urandom_range(0, 11), dbl), pool($urandom_range(0, 11), dbl),
              ce, 5'($urandom()), tg);
      end
      idle("R2 drain");
      idle("R2 drain");
      @(negedge clk);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #2000000;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule